// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block sits between a processor core and a single-port word memory. It carries out atomic operations on aligned 32-bit words: load-reserved, store-conditional, and read-modify-write operations that return the word as it was before the update. Every accepted request runs the same fixed sequence. The unit reads the word, computes the update in the next cycle while the write goes out, and then presents one response cycle.

One reservation register holds a valid bit and a word address. A load-reserved sets it. A store-conditional tests it and always clears it. Any write to the reserved word also clears it, whether the write comes from this unit or arrives on a separate write-observation port. Each request carries two ordering bits. A release request holds back its memory read while an external "writes pending" input is high. An acquire request keeps the request channel closed during its own response cycle, so no later request is accepted before its result is returned.

Top module: `amo_unit`

## Requirements
- R1: Load-reserved (op code 0) returns the addressed memory word unchanged and records a reservation on that word address.
- R2: Store-conditional (op code 1) writes the operand to memory and returns 0 when a valid reservation holds the same word address.
- R3: Store-conditional without a matching valid reservation leaves memory unchanged and returns 1. Every store-conditional clears the reservation, whether it succeeds or fails.
- R4: Op codes 2 add, 3 swap, 4 and, 5 or and 6 xor return the old memory word and write back the old word combined with the operand.
- R5: Op codes 7 max and 8 min compare as signed 32-bit values, and op codes 9 maxu and 10 minu compare as unsigned. Each returns the old word and writes back the selected value.
- R6: A write to the reserved word clears the reservation, whether it is a write by this unit's own operations or a write reported on the observation port. A reported write to a different word leaves the reservation intact.
- R7: The response pulse lasts one cycle and comes in the third cycle after the accepting clock edge when the request is not held by a release.
- R8: The memory read of an operation is followed directly by its write slot, with no other memory read in between.
- R9: A request with the release bit set issues no memory access while writes_pending_i is high, and proceeds once it falls.
- R10: In the response cycle, req_ready_o is low if the request had its acquire bit set, and high otherwise.
- R11: Op codes 11 to 15 return the old word and write nothing.
- R12: After reset, req_ready_o is high, rsp_valid_o and mem_req_o are low, and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_op_i | input | 4 | Operation code |
| req_addr_i | input | AW | Word address |
| req_data_i | input | DW | Operand |
| req_aq_i | input | 1 | Acquire ordering bit |
| req_rl_i | input | 1 | Release ordering bit |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_data_o | output | DW | Old word or store-conditional status |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Read data, valid one cycle after the read strobe |
| writes_pending_i | input | 1 | Earlier writes still outstanding |
| ext_we_i | input | 1 | Another agent writes memory |
| ext_addr_i | input | AW | Word address of that write |

## Verification
After the accepting edge, the read strobe is due in the first cycle, the write slot in the second, and the response in the third. The bench counts negative edges from acceptance and expects the response exactly at the third. Memory contents are checked after that response, by which point the write has landed. The release test holds writes pending high for several cycles and confirms that no strobe leaves the unit. The acquire test samples the ready output in the same cycle as the response.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam logic [3:0] OP_LR   = 4'd0;
  localparam logic [3:0] OP_SC   = 4'd1;
  localparam logic [3:0] OP_ADD  = 4'd2;
  localparam logic [3:0] OP_SWAP = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_MAX  = 4'd7;
  localparam logic [3:0] OP_MIN  = 4'd8;
  localparam logic [3:0] OP_MAXU = 4'd9;
  localparam logic [3:0] OP_MINU = 4'd10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_RD,
    ST_WB,
    ST_RESP
  } seq_state_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] opd_i,
  output logic [DW-1:0] new_o,
  output logic          wr_o
);
  logic lt_s, lt_u;

  assign lt_s = $signed(old_i) < $signed(opd_i);
  assign lt_u = old_i < opd_i;

  always_comb begin
    new_o = opd_i;
    wr_o  = 1'b1;
    unique case (op_i)
      OP_ADD:  new_o = old_i + opd_i;
      OP_SWAP: new_o = opd_i;
      OP_AND:  new_o = old_i & opd_i;
      OP_OR:   new_o = old_i | opd_i;
      OP_XOR:  new_o = old_i ^ opd_i;
      OP_MAX:  new_o = lt_s ? opd_i : old_i;
      OP_MIN:  new_o = lt_s ? old_i : opd_i;
      OP_MAXU: new_o = lt_u ? opd_i : old_i;
      OP_MINU: new_o = lt_u ? old_i : opd_i;
      default: wr_o = 1'b0; // LR, SC (decided by sequencer), reserved codes
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic          own_we_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic          ext_we_i,
  input  logic [AW-1:0] ext_addr_i,
  output logic          hit_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic          ext_hit_cur, own_hit_cur, ext_hit_new;

  assign ext_hit_cur = ext_we_i && (ext_addr_i == addr_q);
  assign own_hit_cur = own_we_i && (own_addr_i == addr_q);
  assign ext_hit_new = ext_we_i && (ext_addr_i == op_addr_i);
  assign hit_o       = valid_q && (addr_q == op_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (set_i) begin
      valid_q <= !ext_hit_new;
      addr_q  <= op_addr_i;
    end else if (clr_i || own_hit_cur || ext_hit_cur) begin
      valid_q <= 1'b0;
    end
  end

  // R6
  ext_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_we_i && valid_q && ext_addr_i == addr_q && !set_i) |=> !valid_q);

  // R3
  sc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !valid_q);
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [3:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic          req_aq_i,
  input  logic          req_rl_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          writes_pending_i,
  output logic [3:0]    op_o,
  output logic [DW-1:0] opd_o,
  input  logic [DW-1:0] alu_new_i,
  input  logic          alu_wr_i,
  input  logic          resv_hit_i,
  output logic          resv_set_o,
  output logic          resv_clr_o
);
  localparam logic [DW-1:0] SC_FAIL = DW'(1);

  seq_state_e    state_q, state_d;
  logic [3:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] opd_q, rsp_q;
  logic          aq_q;
  logic          fire, in_wb, is_sc, sc_ok;

  assign req_ready_o = (state_q == ST_IDLE) || (state_q == ST_RESP && !aq_q);
  assign fire        = req_valid_i && req_ready_o;
  assign in_wb       = state_q == ST_WB;
  assign is_sc       = op_q == OP_SC;
  assign sc_ok       = is_sc && resv_hit_i;

  assign op_o        = op_q;
  assign opd_o       = opd_q;
  assign mem_req_o   = (state_q == ST_RD) || (in_wb && (alu_wr_i || sc_ok));
  assign mem_we_o    = in_wb;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = alu_new_i;
  assign resv_set_o  = in_wb && (op_q == OP_LR);
  assign resv_clr_o  = in_wb && is_sc;
  assign rsp_valid_o = state_q == ST_RESP;
  assign rsp_data_o  = rsp_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_RESP: begin
        if (fire) state_d = (req_rl_i && writes_pending_i) ? ST_HOLD : ST_RD;
        else      state_d = ST_IDLE;
      end
      ST_HOLD: if (!writes_pending_i) state_d = ST_RD;
      ST_RD:   state_d = ST_WB;
      ST_WB:   state_d = ST_RESP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      opd_q   <= '0;
      aq_q    <= 1'b0;
      rsp_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fire) begin
        op_q   <= req_op_i;
        addr_q <= req_addr_i;
        opd_q  <= req_data_i;
        aq_q   <= req_aq_i;
      end
      if (in_wb) rsp_q <= is_sc ? (sc_ok ? '0 : SC_FAIL) : mem_rdata_i;
    end
  end

  // R8
  no_interleave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !(mem_req_o && !mem_we_o));

  // R9
  release_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && req_rl_i && writes_pending_i) |=> !mem_req_o);

  // R7
  rsp_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(mem_req_o && !mem_we_o, 2));

  // R7
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R5
  signed_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && op_q == OP_MAX) |->
      ($signed(mem_wdata_o) >= $signed(mem_rdata_i) && $signed(mem_wdata_o) >= $signed(opd_q)));

  // R1
  lr_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && op_q == OP_LR) |-> !mem_we_o);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [3:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic          req_aq_i,
  input  logic          req_rl_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          writes_pending_i,
  input  logic          ext_we_i,
  input  logic [AW-1:0] ext_addr_i
);
  logic [3:0]    op;
  logic [DW-1:0] opd, alu_new;
  logic          alu_wr, resv_hit, resv_set, resv_clr;

  amo_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i,
    .req_data_i, .req_aq_i, .req_rl_i, .rsp_valid_o, .rsp_data_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .writes_pending_i,
    .op_o(op), .opd_o(opd), .alu_new_i(alu_new), .alu_wr_i(alu_wr),
    .resv_hit_i(resv_hit), .resv_set_o(resv_set), .resv_clr_o(resv_clr)
  );

  amo_alu #(.DW(DW)) u_alu (
    .op_i(op), .old_i(mem_rdata_i), .opd_i(opd), .new_o(alu_new), .wr_o(alu_wr)
  );

  amo_resv #(.AW(AW)) u_resv (
    .clk_i, .rst_ni,
    .set_i(resv_set), .clr_i(resv_clr), .op_addr_i(mem_addr_o),
    .own_we_i(mem_req_o && mem_we_o), .own_addr_i(mem_addr_o),
    .ext_we_i, .ext_addr_i, .hit_o(resv_hit)
  );
endmodule

// File: tb/amo_unit_bench.sv
module amo_unit_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NV = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready;
  logic [3:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_aq = 1'b0, req_rl = 1'b0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          wr_pend = 1'b0;
  logic          ext_we = 1'b0;
  logic [AW-1:0] ext_addr = '0;

  logic [DW-1:0] mem [256];
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  amo_unit #(.AW(AW), .DW(DW)) u_amo_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
    .req_aq_i(req_aq), .req_rl_i(req_rl), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .writes_pending_i(wr_pend),
    .ext_we_i(ext_we), .ext_addr_i(ext_addr)
  );

  // {op, addr, operand, expected response, expected word afterwards}
  localparam logic [107:0] VEC [NV] = '{
    {4'd2,  8'd1, 32'd5,          32'd10,         32'd15},          // R4 add
    {4'd3,  8'd1, 32'd7,          32'd15,         32'd7},           // R4 swap
    {4'd4,  8'd2, 32'h0FF0_FF00,  32'hFFFF_0000,  32'h0FF0_0000},   // R4 and
    {4'd5,  8'd2, 32'h0000_000F,  32'h0FF0_0000,  32'h0FF0_000F},   // R4 or
    {4'd6,  8'd2, 32'h0FF0_0000,  32'h0FF0_000F,  32'h0000_000F},   // R4 xor
    {4'd7,  8'd3, 32'd3,          32'hFFFF_FFFE,  32'd3},           // R5 max signed
    {4'd8,  8'd3, 32'h8000_0000,  32'd3,          32'h8000_0000},   // R5 min signed
    {4'd9,  8'd3, 32'h7FFF_FFFF,  32'h8000_0000,  32'h8000_0000},   // R5 maxu
    {4'd10, 8'd3, 32'd5,          32'h8000_0000,  32'd5},           // R5 minu
    {4'd0,  8'd4, 32'd0,          32'h1234,       32'h1234},        // R1 lr
    {4'd1,  8'd4, 32'hAAAA,       32'd0,          32'hAAAA},        // R2 sc ok
    {4'd1,  8'd4, 32'hBBBB,       32'd1,          32'hAAAA},        // R3 cleared
    {4'd0,  8'd5, 32'd0,          32'h55,         32'h55},          // R1
    {4'd2,  8'd5, 32'd1,          32'h55,         32'h56},          // R6 own write
    {4'd1,  8'd5, 32'd9,          32'd1,          32'h56},          // R6 lost
    {4'd0,  8'd6, 32'd0,          32'd0,          32'd0},           // R1
    {4'd1,  8'd7, 32'd3,          32'd1,          32'd0},           // R3 addr miss
    {4'd1,  8'd6, 32'd4,          32'd1,          32'd0},           // R3 cleared by miss
    {4'd12, 8'd1, 32'd99,         32'd7,          32'd7}            // R11 reserved code
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [3:0] op, input logic [AW-1:0] addr,
                        input logic [DW-1:0] opd, input logic aq,
                        output logic [DW-1:0] data, output int lat, output logic rdy);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_data = opd;
    req_aq = aq; req_rl = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    data = rsp_data;
    rdy  = req_ready;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    int lat;
    logic rdy;
    int saw_req;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[1] = 32'd10; mem[2] = 32'hFFFF_0000; mem[3] = 32'hFFFF_FFFE;
    mem[4] = 32'h1234; mem[5] = 32'h55; mem[8] = 32'h11; mem[9] = 32'h22;
    mem[12] = 32'h40;

    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 ready", req_ready, 1'b1);
    check("R12 rsp_valid", rsp_valid, 1'b0);
    check("R12 mem_req", mem_req, 1'b0);
    rst_n = 1'b1;
    do_req(4'd1, 8'd0, 32'd77, 1'b0, d, lat, rdy);
    check("R12 no reservation after reset", d, 32'd1);
    check("R12 memory untouched", mem[0], 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [107:0] v;
      v = VEC[i];
      do_req(v[107:104], v[103:96], v[95:64], 1'b0, d, lat, rdy);
      check($sformatf("R4/R5 vec%0d response", i), d, v[63:32]);
      check($sformatf("R4/R5 vec%0d memory", i), mem[v[103:96]], v[31:0]);
      check($sformatf("R7 vec%0d latency", i), 32'(lat), 32'd3);
      check($sformatf("R10 vec%0d ready without acquire", i), {31'b0, rdy}, 32'd1);
    end

    // R7 one-cycle pulse
    @(negedge clk);
    check("R7 pulse width", rsp_valid, 1'b0);

    // R6 observed write to reserved word clears it
    do_req(4'd0, 8'd8, 32'd0, 1'b0, d, lat, rdy);
    @(negedge clk); ext_we = 1'b1; ext_addr = 8'd8;
    @(negedge clk); ext_we = 1'b0;
    do_req(4'd1, 8'd8, 32'd5, 1'b0, d, lat, rdy);
    check("R6 external hit sc status", d, 32'd1);
    check("R6 external hit memory", mem[8], 32'h11);

    // R6 observed write elsewhere keeps it
    do_req(4'd0, 8'd9, 32'd0, 1'b0, d, lat, rdy);
    @(negedge clk); ext_we = 1'b1; ext_addr = 8'd10;
    @(negedge clk); ext_we = 1'b0;
    do_req(4'd1, 8'd9, 32'h33, 1'b0, d, lat, rdy);
    check("R6 external miss sc status", d, 32'd0);
    check("R2 sc writes", mem[9], 32'h33);

    // R10 acquire closes ready in response cycle
    do_req(4'd2, 8'd1, 32'd1, 1'b1, d, lat, rdy);
    check("R10 acquire ready", {31'b0, rdy}, 32'd0);
    check("R10 acquire data", d, 32'd7);
    @(negedge clk);
    check("R10 ready after acquire response", req_ready, 1'b1);

    // R9 release waits for pending writes
    @(negedge clk);
    wr_pend = 1'b1;
    req_valid = 1'b1; req_op = 4'd2; req_addr = 8'd12; req_data = 32'd2;
    req_aq = 1'b0; req_rl = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_rl = 1'b0;
    saw_req = 0;
    for (int k = 0; k < 5; k++) begin
      if (mem_req || rsp_valid) saw_req++;
      @(negedge clk);
    end
    check("R9 no access while pending", 32'(saw_req), 32'd0);
    wr_pend = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R9 response after release", rsp_data, 32'h40);
    check("R9 memory after release", mem[12], 32'h42);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule